// File: doc/BRIEF.md
# Byte-Serial Configuration Register Access Port

This block lets local application logic read and write a 32-bit-word configuration register file over a narrow 8-bit path. A single read or write strobe starts an access that carries a 12-bit byte address. The data word then moves one byte per clock cycle, lowest byte first. One acknowledge output serves both directions. On a write it marks the cycle the word is committed. On a read it marks the cycle the first data byte appears.

A second requester, the configuration-request path, shares the same register file and always has priority. While its request line is high, local accesses wait at their arbitration point. Once a local data transfer has started, the configuration path is held off until that transfer has finished. The register file sits outside the block. The block drives a one-cycle enable, a write flag, a word address and the assembled write word, and it samples the file's combinational read data.

The controller has five states. IDLE accepts a lone read or write strobe. WR_COLLECT gathers write bytes 1 to 3. WR_ARB waits for the configuration path to go quiet and then commits. RD_ARB waits the same way and then fetches. RD_SEND streams the four read bytes. The transitions are:
- IDLE→WR_COLLECT on a lone write strobe.
- IDLE→RD_ARB on a lone read strobe.
- WR_COLLECT→WR_ARB after the last byte is gathered.
- WR_ARB→IDLE on commit.
- RD_ARB→RD_SEND on fetch.
- RD_SEND→IDLE after the last byte is sent.

The state stays unchanged in every other case.

Top module: `cfgport_top`

## Requirements
- R1: While `cfg_req` is high, the block never enables the register file. `cfg_gnt` follows `cfg_req` in IDLE, WR_ARB and RD_ARB.
- R2: A write that is complete and waiting in WR_ARB commits, with `rf_en` and `rf_we` high, in the first cycle in which `cfg_req` is low.
- R3: A read waiting in RD_ARB fetches in the first cycle in which `cfg_req` is low. The word it returns includes any configuration-path write granted before that cycle.
- R4: Address bits [1:0] are ignored. The word address is `loc_addr[11:2]`.
- R5: Write byte 0 (bits 7:0) is on `loc_wdata` in the cycle of the write strobe. Bytes 1, 2 and 3 (bits 15:8, 23:16, 31:24) follow on the next three cycles.
- R6: Read data leaves on four consecutive cycles in the order bits 7:0, 15:8, 23:16, 31:24. `loc_ack` is high in the cycle of byte 0.
- R7: `loc_ack` is a single-cycle pulse. For a write with no configuration traffic, it is high four cycles after the strobe cycle, in the commit cycle.
- R8: A strobe that arrives while the block is not in IDLE is ignored. It causes no acknowledge and no register change.
- R9: A read strobe and a write strobe in the same cycle are rejected. There is no acknowledge and no register change.
- R10: `cfg_gnt` stays low during WR_COLLECT and RD_SEND, even if `cfg_req` rises.
- R11: `loc_rdata` is zero outside RD_SEND.
- R12: For a read with no configuration traffic, `loc_ack` and byte 0 appear two cycles after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_rd_stb | input | 1 | Local read strobe, single-cycle |
| loc_wr_stb | input | 1 | Local write strobe, single-cycle, with write byte 0 |
| loc_addr | input | 12 | Byte address, sampled with the strobe |
| loc_wdata | input | 8 | Write data byte |
| loc_rdata | output | 8 | Read data byte, zero when idle |
| loc_ack | output | 1 | Write committed / first read byte valid |
| cfg_req | input | 1 | Configuration path requests the register file |
| cfg_gnt | output | 1 | Configuration path may use the register file this cycle |
| rf_en | output | 1 | Register file access enable |
| rf_we | output | 1 | Register file write flag |
| rf_addr | output | 10 | Register file word address |
| rf_wdata | output | 32 | Word to write |
| rf_rdata | input | 32 | Combinational read word from the file |

## Verification
The assertions assume that each strobe is a single-cycle pulse and that write bytes arrive back-to-back. They also assume that the register file returns read data combinationally and that the configuration path touches the file only in cycles where `cfg_gnt` is high. The bench drives every input on the falling edge. It issues each strobe for exactly one cycle and feeds the three later write bytes on the next three cycles. Its register-file model applies writes only from `rf_en`/`rf_we` and from granted configuration-path writes. Deliberate protocol stress stays inside these assumptions: overlapping strobes while busy, coincident read and write strobes, and `cfg_req` raised in the middle of a transfer.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_COLLECT,
        ST_WR_ARB,
        ST_RD_ARB,
        ST_RD_SEND
    } port_state_e;

endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int BEATS  = 4,
    parameter int BCNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              cfg_req,
    output logic              cap_en,
    output logic [BCNT_W-1:0] cap_lane,
    output logic              addr_load,
    output logic              rd_load,
    output logic              send_en,
    output logic [BCNT_W-1:0] send_lane,
    output logic              commit,
    output logic              ack,
    output logic              cfg_gnt,
    output logic              idle
);

    localparam logic [BCNT_W-1:0] LAST_BEAT = BCNT_W'(BEATS - 1);

    port_state_e       state;
    logic [BCNT_W-1:0] beat;

    // State register with beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (wr_stb && !rd_stb) begin
                        state <= ST_WR_COLLECT;
                        beat  <= BCNT_W'(1);
                    end else if (rd_stb && !wr_stb) begin
                        state <= ST_RD_ARB;
                    end
                end
                ST_WR_COLLECT: begin
                    if (beat == LAST_BEAT) begin
                        state <= ST_WR_ARB;
                        beat  <= '0;
                    end else begin
                        beat <= beat + BCNT_W'(1);
                    end
                end
                ST_WR_ARB: begin
                    if (!cfg_req) state <= ST_IDLE;
                end
                ST_RD_ARB: begin
                    if (!cfg_req) begin
                        state <= ST_RD_SEND;
                        beat  <= '0;
                    end
                end
                ST_RD_SEND: begin
                    if (beat == LAST_BEAT) begin
                        state <= ST_IDLE;
                        beat  <= '0;
                    end else begin
                        beat <= beat + BCNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cap_en    = 1'b0;
        cap_lane  = '0;
        addr_load = 1'b0;
        rd_load   = 1'b0;
        send_en   = 1'b0;
        send_lane = '0;
        commit    = 1'b0;
        ack       = 1'b0;
        cfg_gnt   = 1'b0;
        idle      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle      = 1'b1;
                cfg_gnt   = cfg_req;
                addr_load = wr_stb ^ rd_stb;
                cap_en    = wr_stb && !rd_stb;
            end
            ST_WR_COLLECT: begin
                cap_en   = 1'b1;
                cap_lane = beat;
            end
            ST_WR_ARB: begin
                cfg_gnt = cfg_req;
                commit  = !cfg_req;
                ack     = !cfg_req;
            end
            ST_RD_ARB: begin
                cfg_gnt = cfg_req;
                rd_load = !cfg_req;
            end
            ST_RD_SEND: begin
                send_en   = 1'b1;
                send_lane = beat;
                ack       = (beat == '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfgport_deser.sv
module cfgport_deser #(
    parameter int BEAT_W = 8,
    parameter int BEATS  = 4,
    parameter int BCNT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en,
    input  logic [BCNT_W-1:0]       cap_lane,
    input  logic [BEAT_W-1:0]       din,
    output logic [BEAT_W*BEATS-1:0] word
);

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word[g*BEAT_W +: BEAT_W] <= '0;
            end else if (cap_en && cap_lane == BCNT_W'(g)) begin
                word[g*BEAT_W +: BEAT_W] <= din;
            end
        end
    end

endmodule

// File: rtl/cfgport_ser.sv
module cfgport_ser #(
    parameter int BEAT_W = 8,
    parameter int BEATS  = 4,
    parameter int BCNT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [BEAT_W*BEATS-1:0] word_in,
    input  logic                    send_en,
    input  logic [BCNT_W-1:0]       send_lane,
    output logic [BEAT_W-1:0]       dout
);

    logic [BEAT_W-1:0] lanes [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    lanes[g] <= '0;
            else if (load) lanes[g] <= word_in[g*BEAT_W +: BEAT_W];
        end
    end

    assign dout = send_en ? lanes[send_lane] : '0;

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top #(
    parameter int DATA_W = 32,
    parameter int BEAT_W = 8,
    parameter int ADDR_W = 12,
    localparam int BEATS   = DATA_W / BEAT_W,
    localparam int BCNT_W  = $clog2(BEATS),
    localparam int OFS_W   = $clog2(DATA_W / 8),
    localparam int WADDR_W = ADDR_W - OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_rd_stb,
    input  logic               loc_wr_stb,
    input  logic [ADDR_W-1:0]  loc_addr,
    input  logic [BEAT_W-1:0]  loc_wdata,
    output logic [BEAT_W-1:0]  loc_rdata,
    output logic               loc_ack,
    input  logic               cfg_req,
    output logic               cfg_gnt,
    output logic               rf_en,
    output logic               rf_we,
    output logic [WADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0]  rf_wdata,
    input  logic [DATA_W-1:0]  rf_rdata
);

    logic              cap_en, addr_load, rd_load, send_en, commit, ctl_idle;
    logic [BCNT_W-1:0] cap_lane, send_lane;
    logic [WADDR_W-1:0] waddr_q;
    logic              unused_ofs;

    assign unused_ofs = ^loc_addr[OFS_W-1:0];

    cfgport_ctrl #(.BEATS(BEATS), .BCNT_W(BCNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (loc_rd_stb),
        .wr_stb    (loc_wr_stb),
        .cfg_req   (cfg_req),
        .cap_en    (cap_en),
        .cap_lane  (cap_lane),
        .addr_load (addr_load),
        .rd_load   (rd_load),
        .send_en   (send_en),
        .send_lane (send_lane),
        .commit    (commit),
        .ack       (loc_ack),
        .cfg_gnt   (cfg_gnt),
        .idle      (ctl_idle)
    );

    cfgport_deser #(.BEAT_W(BEAT_W), .BEATS(BEATS), .BCNT_W(BCNT_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_lane (cap_lane),
        .din      (loc_wdata),
        .word     (rf_wdata)
    );

    cfgport_ser #(.BEAT_W(BEAT_W), .BEATS(BEATS), .BCNT_W(BCNT_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rd_load),
        .word_in   (rf_rdata),
        .send_en   (send_en),
        .send_lane (send_lane),
        .dout      (loc_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         waddr_q <= '0;
        else if (addr_load) waddr_q <= loc_addr[ADDR_W-1:OFS_W];
    end

    assign rf_en   = commit | rd_load;
    assign rf_we   = commit;
    assign rf_addr = waddr_q;

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
    parameter int BEAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic              cfg_req,
    input logic              cfg_gnt,
    input logic              rf_en,
    input logic              rf_we,
    input logic              ack,
    input logic [BEAT_W-1:0] rdata,
    input logic              ctl_idle
);

    p_cfg_priority_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !rf_en);

    p_gnt_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_idle && cfg_req) |-> cfg_gnt);

    p_commit_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && rf_we) |-> ack);

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_read_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && !rf_we) |=> ack);

    p_reject_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_idle && rd_stb && wr_stb) |=> ctl_idle);

    p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_idle |-> (rdata == '0));

    p_send_holds_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rf_en) |-> !cfg_gnt);

endmodule

bind cfgport_top cfgport_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (loc_rd_stb),
    .wr_stb   (loc_wr_stb),
    .cfg_req  (cfg_req),
    .cfg_gnt  (cfg_gnt),
    .rf_en    (rf_en),
    .rf_we    (rf_we),
    .ack      (loc_ack),
    .rdata    (loc_rdata),
    .ctl_idle (ctl_idle)
);

// File: tb/cfgport_top_tb_top.sv
module cfgport_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_rd_stb = 1'b0, loc_wr_stb = 1'b0;
    logic [11:0] loc_addr = '0;
    logic [7:0]  loc_wdata = '0;
    logic [7:0]  loc_rdata;
    logic        loc_ack, cfg_gnt, rf_en, rf_we;
    logic        cfg_req = 1'b0;
    logic [9:0]  rf_addr;
    logic [31:0] rf_wdata, rf_rdata;

    // configuration-path model
    logic        cfg_do_wr = 1'b0;
    logic [9:0]  cfg_waddr = '0;
    logic [31:0] cfg_wval = '0;

    logic [31:0] mem [1024];

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cfgport_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .loc_rd_stb(loc_rd_stb), .loc_wr_stb(loc_wr_stb),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_ack(loc_ack),
        .cfg_req(cfg_req), .cfg_gnt(cfg_gnt),
        .rf_en(rf_en), .rf_we(rf_we), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    // register-file model
    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) begin
        if (rf_en && rf_we) mem[rf_addr] <= rf_wdata;
        if (cfg_gnt && cfg_do_wr) mem[cfg_waddr] <= cfg_wval;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // ends in WR_ARB at a falling edge
    task automatic send_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        loc_wr_stb = 1'b1; loc_addr = a; loc_wdata = d[7:0];
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            loc_wr_stb = 1'b0; loc_wdata = d[8*i +: 8];
        end
        @(negedge clk);
        loc_wdata = '0;
    endtask

    task automatic write_word(input logic [11:0] a, input logic [31:0] d);
        send_write(a, d);
        @(negedge clk);
    endtask

    // ends in RD_ARB at a falling edge
    task automatic start_read(input logic [11:0] a);
        @(negedge clk);
        loc_rd_stb = 1'b1; loc_addr = a;
        @(negedge clk);
        loc_rd_stb = 1'b0;
    endtask

    task automatic read_check(input logic [31:0] exp, input string req);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk); #1;
            chk(loc_rdata == exp[8*b +: 8], {req, " R6 byte order"}, 32'(loc_rdata), 32'(exp[8*b +: 8]));
            chk(loc_ack == (b == 0), "R6 ack with byte0", 32'(loc_ack), 32'(b == 0));
        end
        @(negedge clk); #1;
        chk(loc_rdata == 8'h00, "R11 rdata zero when idle", 32'(loc_rdata), 32'h0);
    endtask

    task automatic t_reset();
        #1;
        chk(loc_ack == 1'b0, "R7 ack low at reset", 32'(loc_ack), 32'h0);
        chk(loc_rdata == 8'h00, "R11 rdata zero at reset", 32'(loc_rdata), 32'h0);
        chk(cfg_gnt == 1'b0, "R1 no grant without request", 32'(cfg_gnt), 32'h0);
        cfg_req = 1'b1; #1;
        chk(cfg_gnt == 1'b1, "R1 grant in idle", 32'(cfg_gnt), 32'h1);
        cfg_req = 1'b0;
    endtask

    task automatic t_write_read();
        send_write(12'h040, 32'hA1B2C3D4); #1;
        chk(loc_ack == 1'b1, "R7 write ack four cycles after strobe", 32'(loc_ack), 32'h1);
        @(negedge clk); #1;
        chk(loc_ack == 1'b0, "R7 ack single pulse", 32'(loc_ack), 32'h0);
        chk(mem[10'h010] == 32'hA1B2C3D4, "R5 assembled write word", mem[10'h010], 32'hA1B2C3D4);
        start_read(12'h043); #1;
        chk(loc_ack == 1'b0, "R12 no ack one cycle after strobe", 32'(loc_ack), 32'h0);
        read_check(32'hA1B2C3D4, "R4 R12 offset ignored");
    endtask

    task automatic t_write_held();
        cfg_req = 1'b1;
        send_write(12'h080, 32'h11223344); #1;
        chk(loc_ack == 1'b0, "R2 write held while cfg pending", 32'(loc_ack), 32'h0);
        chk(cfg_gnt == 1'b1, "R1 cfg wins in WR_ARB", 32'(cfg_gnt), 32'h1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(loc_ack == 1'b0, "R2 write still held", 32'(loc_ack), 32'h0);
        end
        cfg_req = 1'b0; #1;
        chk(loc_ack == 1'b1, "R2 commit when cfg drops", 32'(loc_ack), 32'h1);
        @(negedge clk); #1;
        chk(mem[10'h020] == 32'h11223344, "R2 held write landed", mem[10'h020], 32'h11223344);
    endtask

    task automatic t_read_held();
        cfg_req = 1'b1; cfg_do_wr = 1'b1; cfg_waddr = 10'h020; cfg_wval = 32'hCAFEF00D;
        start_read(12'h080); #1;
        chk(loc_ack == 1'b0, "R3 read held while cfg pending", 32'(loc_ack), 32'h0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); #1;
            chk(loc_ack == 1'b0, "R3 read still held", 32'(loc_ack), 32'h0);
        end
        cfg_req = 1'b0; cfg_do_wr = 1'b0;
        read_check(32'hCAFEF00D, "R3 sees cfg write");
    endtask

    task automatic t_cfg_mid();
        write_word(12'h0C0, 32'h5A6B7C8D);
        start_read(12'h0C0);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            cfg_req = 1'b1; #1;
            chk(cfg_gnt == 1'b0, "R10 cfg held during read beats", 32'(cfg_gnt), 32'h0);
            chk(loc_rdata == 8'(32'h5A6B7C8D >> (8*b)), "R10 beats continue", 32'(loc_rdata), 32'h5A6B7C8D >> (8*b));
        end
        @(negedge clk); #1;
        chk(cfg_gnt == 1'b1, "R10 cfg granted after transfer", 32'(cfg_gnt), 32'h1);
        cfg_req = 1'b0;
        // cfg during write collection
        @(negedge clk);
        loc_wr_stb = 1'b1; loc_addr = 12'h0C4; loc_wdata = 8'h01;
        @(negedge clk);
        loc_wr_stb = 1'b0; cfg_req = 1'b1; #1;
        chk(cfg_gnt == 1'b0, "R10 cfg held during write beats", 32'(cfg_gnt), 32'h0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        cfg_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        write_word(12'h100, 32'h0BADBEEF);
        start_read(12'h100);
        loc_wr_stb = 1'b1; loc_addr = 12'h140; loc_wdata = 8'hEE;
        @(negedge clk);
        loc_wr_stb = 1'b0; loc_rd_stb = 1'b1; #1;
        chk(loc_rdata == 8'hEF, "R8 read unaffected by strobe", 32'(loc_rdata), 32'hEF);
        @(negedge clk);
        loc_rd_stb = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            chk(loc_ack == 1'b0, "R8 no ack from ignored strobe", 32'(loc_ack), 32'h0);
        end
        start_read(12'h140);
        read_check(32'h0, "R8 ignored write left register");
    endtask

    task automatic t_both();
        write_word(12'h200, 32'h01020304);
        @(negedge clk);
        loc_rd_stb = 1'b1; loc_wr_stb = 1'b1; loc_addr = 12'h200; loc_wdata = 8'hFF;
        @(negedge clk);
        loc_rd_stb = 1'b0; loc_wr_stb = 1'b0;
        for (int i = 0; i < 6; i++) begin
            #1;
            chk(loc_ack == 1'b0, "R9 both strobes rejected", 32'(loc_ack), 32'h0);
            @(negedge clk);
        end
        loc_wdata = '0;
        start_read(12'h200);
        read_check(32'h01020304, "R9 register unchanged");
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_write_held();
        t_read_held();
        t_cfg_mid();
        t_busy_ignore();
        t_both();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        report();
    end

endmodule